// File: doc/BRIEF.md
# Serial EEPROM Byte Read/Write Bus Master

This block is a two-wire bus master for a small serial EEPROM that uses a single address byte. A host pulses a start input together with an operation select, a 3-bit device select, a byte address and write data. The block then runs one complete bus transaction on its own and reports back with a one-cycle done pulse, an error flag and, for a read, the received byte.

A write sends the device byte with the write bit, the byte address and the data byte, then a STOP. It does not wait for the memory's internal write cycle to finish. A read first sets the memory's address pointer with a write that carries only the address. It then issues a repeated START with no STOP before it, sends the device byte with the read bit, clocks in one byte, answers with a NAK and ends with a STOP.

Before any START the block checks that the bus is idle, and it aborts if the bus is not idle. Both bus lines are open-drain. The block only ever pulls a line low or releases it, and it reads the lines back through a synchronizer.

Top module: `eeprom_rw_master`

## Requirements
- R1: The device byte is, from MSB to LSB, the four bits 1010, then the 3-bit device select, then a direction bit that is 0 for write and 1 for read.
- R2: When a command is accepted, both lines stay released for one high phase and are then sampled. If either line reads low, the block sets the error flag and pulses done, and it pulls neither line low during that command.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. At no other time does SDA change while SCL is high. A successful write produces exactly one START and one STOP, and a successful read produces two STARTs and one STOP.
- R4: Bytes go out and come in most significant bit first. Received bits are sampled at the end of the SCL high phase.
- R5: After each byte it sends, the master releases SDA for a ninth clock and samples the acknowledge. A high sample sets the error flag, issues a STOP and ends the command, and no further byte is sent.
- R6: A write sends, in order, the device byte (write), the byte address and the data byte, and then a STOP.
- R7: A read sends the device byte (write) and the byte address, then a repeated START with no STOP between, then the device byte (read). It shifts in 8 bits, presents them on the read data output, leaves SDA released on the ninth clock (NAK) and then sends a STOP.
- R8: Every interval in which the master holds SCL low lasts exactly LOW_CYC clocks. The data-bit SCL high phases last HIGH_CYC clocks. Both parameters are at least 4.
- R9: Done is a single-cycle pulse, once per accepted command, whether the command succeeded or failed. The error flag is valid with done and holds until the next command is accepted.
- R10: A start pulse that arrives while a command is in progress is ignored. It does not change the running transaction and does not cause a second one.
- R11: After reset, and whenever the block is idle, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start pulse, taken only when idle |
| op_rd_i | input | 1 | 1 = random read, 0 = byte write |
| dev_sel_i | input | 3 | Programmable device select bits |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Last byte read |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Command failed (bus busy or no acknowledge) |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |

## Verification
The bench targets four things: a NAK on each byte position of both writes and reads, SDA or SCL held low by another party at command time, a second start pulse arriving in the middle of a transaction, and the byte addresses 0x00 and 0xFF.

- A design that ignores a NAK would keep clocking bytes, so the bench sees extra received bytes and a missing error.
- A design that skips the idle check would drive the bus and log a spurious START.
- One that accepts a command while busy would produce a second done pulse or an extra START.
- A repeated START placed wrongly, or a STOP placed before it, shows up in the START/STOP counts.
- A wrong bit order or direction bit shows up in the bytes that the bench's memory model assembles.

// File: rtl/eeprom_rw_pkg.sv
package eeprom_rw_pkg;
   localparam int BYTE_W = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CHECK, ST_START, ST_BLO, ST_BHI,
      ST_RSLO, ST_RSHI, ST_PLO, ST_PHI, ST_PREL, ST_DONE
   } state_t;

   typedef enum logic [2:0] {
      BY_DEVW, BY_ADDR, BY_DATA, BY_DEVR, BY_RX
   } byte_t;

   function automatic logic [BYTE_W-1:0] dev_byte(input logic [2:0] sel, input logic rd);
      return {DEV_TYPE, sel, rd};
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '1;
               else if (i == 0) stg[i] <= d;
               else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
   parameter int LOW_CYC  = 6,
   parameter int HIGH_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hi_sel,
   output logic mid,
   output logic last
);
   localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int CW   = $clog2(MAXC);

   logic [CW-1:0] cnt, len_m1, half;

   assign len_m1 = hi_sel ? CW'(HIGH_CYC - 1) : CW'(LOW_CYC - 1);
   assign half   = hi_sel ? CW'(HIGH_CYC / 2) : CW'(LOW_CYC / 2);
   assign last   = run && (cnt == len_m1);
   assign mid    = run && (cnt == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || last) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         ser_in,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[W-2:0], ser_in};
   end
endmodule

// File: rtl/eeprom_rw_master.sv
module eeprom_rw_master
   import eeprom_rw_pkg::*;
#(
   parameter int LOW_CYC     = 6,
   parameter int HIGH_CYC    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_rd_i,
   input  logic [2:0]        dev_sel_i,
   input  logic [BYTE_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic              done_o,
   output logic              err_o,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   input  logic              scl_i,
   input  logic              sda_i
);
   localparam int ACK_BIT = BYTE_W;

   generate
      if (LOW_CYC < 4) begin : g_bad_low
         $error("LOW_CYC must be at least 4");
      end
      if (HIGH_CYC < 4 || HIGH_CYC <= SYNC_STAGES + 1) begin : g_bad_high
         $error("HIGH_CYC must be at least 4 and exceed the synchronizer depth");
      end
   endgenerate

   state_t            state_q;
   byte_t             byte_q;
   logic [3:0]        bit_q;
   logic              rd_q, sda_oe_q, err_q;
   logic [2:0]        sel_q;
   logic [BYTE_W-1:0] addr_q, wdata_q, rdata_q, sh_q, sh_val;
   logic              scl_s, sda_s, ph_mid, ph_last, hi_phase, run, tx_byte;
   logic              sh_load, sh_shift;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
   );

   assign run      = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign hi_phase = !(state_q inside {ST_BLO, ST_RSLO, ST_PLO});

   i2c_phase_timer #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .hi_sel(hi_phase),
      .mid(ph_mid), .last(ph_last)
   );

   assign tx_byte  = (byte_q != BY_RX);
   assign sh_load  = ph_last && ((state_q == ST_START) ||
                                 (state_q == ST_BHI && bit_q == 4'(ACK_BIT)));
   assign sh_shift = ph_last && (state_q == ST_BHI) && (bit_q != 4'(ACK_BIT));

   always_comb begin
      if (state_q == ST_START)     sh_val = dev_byte(sel_q, byte_q == BY_DEVR);
      else if (byte_q == BY_DEVW)  sh_val = addr_q;
      else                         sh_val = wdata_q;
   end

   i2c_byte_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
      .shift(sh_shift), .ser_in(sda_s), .q(sh_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         byte_q   <= BY_DEVW;
         bit_q    <= '0;
         rd_q     <= 1'b0;
         sel_q    <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         sda_oe_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               rd_q     <= op_rd_i;
               sel_q    <= dev_sel_i;
               addr_q   <= addr_i;
               wdata_q  <= wdata_i;
               err_q    <= 1'b0;
               sda_oe_q <= 1'b0;
               state_q  <= ST_CHECK;
            end
            ST_CHECK: if (ph_last) begin
               if (scl_s && sda_s) begin
                  byte_q   <= BY_DEVW;
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_START;
               end else begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_START: if (ph_last) begin
               bit_q   <= '0;
               state_q <= ST_BLO;
            end
            ST_BLO: begin
               if (ph_mid)
                  sda_oe_q <= (bit_q != 4'(ACK_BIT)) && tx_byte && !sh_q[BYTE_W-1];
               if (ph_last) state_q <= ST_BHI;
            end
            ST_BHI: if (ph_last) begin
               if (bit_q != 4'(ACK_BIT)) begin
                  bit_q   <= bit_q + 1'b1;
                  state_q <= ST_BLO;
               end else begin
                  bit_q <= '0;
                  if (!tx_byte) begin
                     rdata_q <= sh_q;
                     state_q <= ST_PLO;
                  end else if (sda_s) begin
                     err_q   <= 1'b1;
                     state_q <= ST_PLO;
                  end else begin
                     unique case (byte_q)
                        BY_DEVW: begin byte_q <= BY_ADDR; state_q <= ST_BLO; end
                        BY_ADDR: if (rd_q) begin
                                    byte_q  <= BY_DEVR;
                                    state_q <= ST_RSLO;
                                 end else begin
                                    byte_q  <= BY_DATA;
                                    state_q <= ST_BLO;
                                 end
                        BY_DEVR: begin byte_q <= BY_RX; state_q <= ST_BLO; end
                        default: state_q <= ST_PLO;
                     endcase
                  end
               end
            end
            ST_RSLO: begin
               if (ph_mid)  sda_oe_q <= 1'b0;
               if (ph_last) state_q  <= ST_RSHI;
            end
            ST_RSHI: if (ph_last) begin
               sda_oe_q <= 1'b1;
               state_q  <= ST_START;
            end
            ST_PLO: begin
               if (ph_mid)  sda_oe_q <= 1'b1;
               if (ph_last) state_q  <= ST_PHI;
            end
            ST_PHI: if (ph_last) begin
               sda_oe_q <= 1'b0;
               state_q  <= ST_PREL;
            end
            ST_PREL: if (ph_last) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign scl_oe_o = !hi_phase;
   assign sda_oe_o = sda_oe_q;
   assign done_o   = (state_q == ST_DONE);
   assign err_o    = err_q;
   assign rdata_o  = rdata_q;
endmodule

// File: rtl/eeprom_rw_master_chk.sv
module eeprom_rw_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       done_o,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       in_idle,
   input logic       in_start,
   input logic       in_stop_rel,
   input logic [7:0] addr_lat
);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      in_idle |-> (!scl_oe && !sda_oe));

   a_r3_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && $past(!scl_oe) && !$stable(sda_oe)) |-> (in_start || in_stop_rel));

   a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_idle && $past(!in_idle)) |-> $stable(addr_lat));

   a_r11_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!scl_oe && !sda_oe));
endmodule

bind eeprom_rw_master eeprom_rw_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .done_o(done_o),
   .scl_oe(scl_oe_o), .sda_oe(sda_oe_o),
   .in_idle(state_q == eeprom_rw_pkg::ST_IDLE),
   .in_start(state_q == eeprom_rw_pkg::ST_START),
   .in_stop_rel(state_q == eeprom_rw_pkg::ST_PREL),
   .addr_lat(addr_q)
);

// File: tb/eeprom_rw_master_test.sv
`timescale 1ns/1ps
module eeprom_rw_master_test;
   localparam int LOW_CYC = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, op_rd_i = 1'b0;
   logic [2:0] dev_sel_i = '0;
   logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;
   logic done_o, err_o, scl_oe, sda_oe;
   logic slv_low = 1'b0, hold_scl = 1'b0, hold_sda = 1'b0;
   logic scl_ln, sda_ln;

   always #2.5 clk = ~clk;

   assign scl_ln = !(scl_oe || hold_scl);
   assign sda_ln = !(sda_oe || slv_low || hold_sda);

   eeprom_rw_master uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_rd_i(op_rd_i),
      .dev_sel_i(dev_sel_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .scl_i(scl_ln), .sda_i(sda_ln)
   );

   int n_chk = 0, n_fail = 0;

   // memory model state
   logic [7:0] mem [256];
   logic [7:0] rec [8];
   int rec_n, starts, stops, done_cnt, bad_low, low_len, nack_at, bitc, bidx;
   logic drv_seen, mack, rd_ph, pend, pscl, psda;
   logic [7:0] sh, ptr;

   function automatic logic [7:0] exp_dev(input logic [2:0] s, input logic rd);
      return {4'b1010, s, rd};
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         pscl = 1'b1; psda = 1'b1; bitc = -1; rd_ph = 0; pend = 0; slv_low = 0; low_len = 0;
      end else begin
         if (scl_oe || sda_oe) drv_seen = 1'b1;
         if (done_o) done_cnt++;
         if (pscl && scl_ln && psda && !sda_ln) begin
            starts++; bitc = -1; bidx = 0; rd_ph = 0; pend = 0; slv_low = 0;
         end else if (pscl && scl_ln && !psda && sda_ln) begin
            stops++; bitc = -1; rd_ph = 0; pend = 0; slv_low = 0;
         end else if (!pscl && scl_ln) begin
            if (low_len > 0 && low_len != LOW_CYC) bad_low++;
            if (bitc >= 0 && bitc < 8 && !rd_ph) sh = {sh[6:0], sda_ln};
            if (bitc == 8 && rd_ph) mack = sda_ln;
         end else if (pscl && !scl_ln) begin
            if (bitc < 0) bitc = 0;
            else begin
               bitc++;
               if (bitc == 8) begin
                  if (!rd_ph) begin
                     if (rec_n < 8) rec[rec_n] = sh;
                     if (bidx == 1) ptr = sh;
                     if (bidx == 2) mem[ptr] = sh;
                     slv_low = (rec_n != nack_at);
                     if (bidx == 0 && sh[0] && rec_n != nack_at) pend = 1;
                     rec_n++; bidx++;
                  end else slv_low = 1'b0;
               end else if (bitc == 9) begin
                  bitc = 0; slv_low = 1'b0;
                  if (pend) begin pend = 0; rd_ph = 1; slv_low = !mem[ptr][7]; end
                  else if (rd_ph) rd_ph = 0;
               end else if (rd_ph) slv_low = !mem[ptr][7-bitc];
            end
         end
         if (scl_oe) low_len++; else if (scl_ln) low_len = 0;
         pscl = scl_ln; psda = sda_ln;
      end
   end

   // rd, sel, address, data, NAK position (-1 none), kind: 0 normal, 1 poke, 2 bus held
   task automatic run_cmd(input logic rd, input logic [2:0] s, input logic [7:0] a,
                          input logic [7:0] d, input int nk, input int kind);
      int n = 0;
      logic [7:0] exp_rd;
      exp_rd = mem[a];
      rec_n = 0; starts = 0; stops = 0; done_cnt = 0; drv_seen = 0; bad_low = 0;
      nack_at = nk; mack = 0;
      @(negedge clk);
      start_i = 1; op_rd_i = rd; dev_sel_i = s; addr_i = a; wdata_i = d;
      @(negedge clk);
      start_i = 0;
      if (kind == 1) begin
         repeat (120) @(negedge clk);
         start_i = 1; op_rd_i = !rd; addr_i = ~a; dev_sel_i = ~s;
         @(negedge clk);
         start_i = 0;
      end
      while (!done_o && n < 20000) begin @(negedge clk); n++; end
      repeat (20) @(negedge clk);
      chk("R9 single done pulse", done_cnt, 1);
      chk("R11 lines released after command", {scl_oe, sda_oe}, 0);
      if (kind == 2) begin
         chk("R2 error on busy bus", err_o, 1);
         chk("R2 no line driven", drv_seen, 0);
         chk("R2 no start seen", starts, 0);
      end else if (nk >= 0) begin
         chk("R5 error on NAK", err_o, 1);
         chk("R5 bytes sent up to NAK", rec_n, nk + 1);
         chk("R5 stop after NAK", stops, 1);
         chk("R3 start count on NAK", starts, (rd && nk == 2) ? 2 : 1);
      end else begin
         chk("R9 no error", err_o, 0);
         chk("R1 R4 device byte write", rec[0], exp_dev(s, 1'b0));
         chk("R4 byte address", rec[1], a);
         chk("R8 SCL low width", bad_low, 0);
         chk("R3 stop count", stops, 1);
         if (rd) begin
            chk("R7 byte count", rec_n, 3);
            chk("R1 R7 device byte read", rec[2], exp_dev(s, 1'b1));
            chk("R7 read data", rdata_o, exp_rd);
            chk("R7 master NAK", mack, 1);
            chk("R3 R7 repeated start", starts, 2);
         end else begin
            chk("R6 byte count", rec_n, 3);
            chk("R6 data byte", rec[2], d);
            chk("R6 memory written", mem[a], d);
            chk("R3 R6 single start", starts, 1);
         end
         if (kind == 1) chk("R10 busy start ignored", rec[1], a);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED01));
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 3));
      rec_n = 0; starts = 0; stops = 0; done_cnt = 0; bad_low = 0; bidx = 0;
      repeat (4) @(negedge clk);
      chk("R11 reset lines released", {scl_oe, sda_oe}, 0);
      chk("R9 reset done low", done_o, 0);
      chk("R9 reset err low", err_o, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);

      run_cmd(0, 3'd5, 8'h3C, 8'hA5, -1, 0);
      run_cmd(1, 3'd5, 8'h3C, 8'h00, -1, 0);
      run_cmd(0, 3'd0, 8'h00, 8'h81, -1, 0);
      run_cmd(1, 3'd7, 8'hFF, 8'h00, -1, 0);
      run_cmd(1, 3'd0, 8'h00, 8'h00, -1, 0);
      for (int k = 0; k < 3; k++) run_cmd(0, 3'd2, 8'h10, 8'h5A, k, 0);
      for (int k = 0; k < 3; k++) run_cmd(1, 3'd6, 8'h20, 8'h00, k, 0);
      run_cmd(1, 3'd1, 8'h20, 8'h00, -1, 0);

      hold_sda = 1; repeat (5) @(negedge clk);
      run_cmd(0, 3'd1, 8'h44, 8'h11, -1, 2);
      hold_sda = 0; repeat (5) @(negedge clk);
      hold_scl = 1; repeat (5) @(negedge clk);
      run_cmd(1, 3'd1, 8'h44, 8'h11, -1, 2);
      hold_scl = 0; repeat (5) @(negedge clk);

      run_cmd(0, 3'd3, 8'h77, 8'hC3, -1, 1);
      run_cmd(1, 3'd3, 8'h77, 8'h00, -1, 1);

      for (int i = 0; i < 40; i++)
         run_cmd(1'($urandom), 3'($urandom), 8'($urandom), 8'($urandom), -1, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule